// File: doc/BRIEF.md
# Vertical Lock Flywheel

This block decides whether a display timing chain is phased up with incoming video. Each time the internal vertical pulse fires, it looks for a reference vertical pulse close to it in time, measured in horizontal periods. Each such check counts as one field. The reference comes from one of two strobes, picked by a select input. One strobe is recovered from composite sync. The other comes from a dedicated vertical input.

While unlocked, the block issues a rephase strobe after every selected reference pulse, so that the internal timing restarts on each pulse. Once enough fields in a row have shown coincidence, the lock flag rises. From then on the rephase strobe is held off, and the internal timing coasts on its own, ignoring stray reference pulses. Lock is dropped only after a longer run of consecutive fields without coincidence. The lock flag is meant to tighten the noise filtering of the data slicer downstream.

All pulse inputs and `h_tick` are single-cycle strobes in the `clk` domain.

Top module: `vlock_flywheel`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `lock` and `rephase` are 0.
- R2: With `ref_sel` = 0 only `csync_vpulse` counts as the reference; with `ref_sel` = 1 only `pin_vpulse` counts. Pulses on the other line have no effect on `rephase` or `lock`.
- R3: While `lock` is 0, `rephase` is 1 for exactly the one cycle after each selected reference pulse.
- R4: Coincidence is judged by counting the `h_tick` cycles that lie strictly between the internal pulse and the reference pulse, in either order. A field is a hit when that count is at most `WIN_H` (default 2), and a miss when it is larger or when no reference pulse comes.
- R5: `lock` rises one cycle after the event that resolves the `LOCK_FIELDS`-th (default 4) consecutive hit field.
- R6: A miss while unlocked restarts the hit count from zero.
- R7: While `lock` is 1, `rephase` stays 0 in the following cycle, whatever the reference lines do.
- R8: `lock` falls one cycle after the `UNLOCK_FIELDS`-th (default 8) consecutive miss field. Any hit while locked restarts the miss count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_tick | input | 1 | One-cycle strobe once per horizontal period |
| csync_vpulse | input | 1 | Reference vertical strobe recovered from composite sync |
| pin_vpulse | input | 1 | Reference vertical strobe from the dedicated vertical input |
| ref_sel | input | 1 | Reference source: 0 composite sync, 1 dedicated input |
| int_vpulse | input | 1 | Internally generated vertical strobe, one per field |
| lock | output | 1 | Timing locked to the reference |
| rephase | output | 1 | Restart strobe for internal timing, issued only while unlocked |

## Verification
A corrupted hit or miss counter shows at the ports as `lock` changing one or more fields too early or too late. The bench therefore checks `lock` at the end of each field and, through its reference model, in every cycle. A bad window counter or age counter turns a hit into a miss within the same field. This is probed with reference offsets of exactly `WIN_H` and `WIN_H`+1 horizontal periods on both sides of the internal pulse. A wrong lock state shows up in `rephase` within one cycle of the next reference pulse, so the bench counts rephase strobes per field and sends pulses on both lines, including the unselected one.

// File: rtl/vlock_pkg.sv
package vlock_pkg;
    // Outcome of one field's coincidence test
    typedef enum logic [1:0] {
        EVT_NONE = 2'd0,
        EVT_HIT  = 2'd1,
        EVT_MISS = 2'd2
    } fld_evt_e;
endpackage

// File: rtl/vlock_ref_track.sv
// Picks the reference source and tracks horizontal periods since its last pulse.
module vlock_ref_track #(
    parameter int WIN_H = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic h_tick,
    input  logic csync_vpulse,
    input  logic pin_vpulse,
    input  logic ref_sel,
    output logic ref_now,
    output logic ref_recent
);
    localparam int AGE_W = $clog2(WIN_H + 2);
    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(WIN_H + 1);
    localparam logic [AGE_W-1:0] AGE_WIN = AGE_W'(WIN_H);

    typedef struct packed {
        logic [AGE_W-1:0] age;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d   = trk_q;
        ref_now = ref_sel ? pin_vpulse : csync_vpulse;
        // A tick in the reference cycle itself is not "between" the pulses
        if (ref_now) begin
            trk_d.age = '0;
        end else if (h_tick && (trk_q.age != AGE_SAT)) begin
            trk_d.age = trk_q.age + 1'b1;
        end
        ref_recent = ref_now || (trk_q.age <= AGE_WIN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.age <= AGE_SAT;
        end else begin
            trk_q <= trk_d;
        end
    end

    // R4: the age counter never runs past its saturation value
    a_r4_age_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.age <= AGE_SAT);

    // R4: a selected reference pulse always restarts the age
    a_r4_age_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ref_now |=> (trk_q.age == '0));
endmodule

// File: rtl/vlock_window.sv
// Judges each field as hit or miss against a +/- WIN_H horizontal window.
module vlock_window
    import vlock_pkg::*;
#(
    parameter int WIN_H = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     h_tick,
    input  logic     int_vpulse,
    input  logic     ref_now,
    input  logic     ref_recent,
    output fld_evt_e fld_evt
);
    localparam int CNT_W = (WIN_H < 1) ? 1 : $clog2(WIN_H + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_H);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] cnt;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d   = win_q;
        fld_evt = EVT_NONE;
        if (win_q.open) begin
            // Waiting for a late reference; further internal pulses are ignored
            if (ref_now) begin
                fld_evt    = EVT_HIT;
                win_d.open = 1'b0;
            end else if (h_tick) begin
                if (win_q.cnt == CNT_LAST) begin
                    fld_evt    = EVT_MISS;
                    win_d.open = 1'b0;
                end else begin
                    win_d.cnt = win_q.cnt + 1'b1;
                end
            end
        end else if (int_vpulse) begin
            if (ref_recent) begin
                fld_evt = EVT_HIT;
            end else begin
                win_d.open = 1'b1;
                win_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    // R4: the open window never counts beyond WIN_H horizontal periods
    a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.open |-> (win_q.cnt <= CNT_LAST));

    // R4: a window opens only on an internal pulse
    a_r4_open_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_q.open) |-> $past(int_vpulse));
endmodule

// File: rtl/vlock_state.sv
// Hysteretic lock decision and rephase strobe generation.
module vlock_state
    import vlock_pkg::*;
#(
    parameter int LOCK_FIELDS   = 4,
    parameter int UNLOCK_FIELDS = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ref_now,
    input  fld_evt_e fld_evt,
    output logic     lock,
    output logic     rephase
);
    localparam int HIT_W  = $clog2(LOCK_FIELDS + 1);
    localparam int MISS_W = $clog2(UNLOCK_FIELDS + 1);
    localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(LOCK_FIELDS - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(UNLOCK_FIELDS - 1);

    typedef struct packed {
        logic              lock;
        logic              rephase;
        logic [HIT_W-1:0]  hits;
        logic [MISS_W-1:0] misses;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d         = lk_q;
        // Pulse-for-pulse restart only while unlocked
        lk_d.rephase = ref_now && !lk_q.lock;
        if (!lk_q.lock) begin
            if (fld_evt == EVT_HIT) begin
                if (lk_q.hits == HIT_LAST) begin
                    lk_d.lock   = 1'b1;
                    lk_d.hits   = '0;
                    lk_d.misses = '0;
                end else begin
                    lk_d.hits = lk_q.hits + 1'b1;
                end
            end else if (fld_evt == EVT_MISS) begin
                lk_d.hits = '0;
            end
        end else begin
            if (fld_evt == EVT_MISS) begin
                if (lk_q.misses == MISS_LAST) begin
                    lk_d.lock   = 1'b0;
                    lk_d.hits   = '0;
                    lk_d.misses = '0;
                end else begin
                    lk_d.misses = lk_q.misses + 1'b1;
                end
            end else if (fld_evt == EVT_HIT) begin
                lk_d.misses = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign lock    = lk_q.lock;
    assign rephase = lk_q.rephase;

    // R5: lock rises only when the last needed hit arrives
    a_r5_lock_after_hits: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lk_q.lock) |-> ($past(lk_q.hits) == HIT_LAST));

    // R6: the hit count stays below the lock threshold
    a_r6_hits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q.hits <= HIT_LAST);

    // R7: no rephase strobe in the cycle after a locked cycle
    a_r7_no_rephase_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q.lock |=> !lk_q.rephase);

    // R8: lock falls only when the last tolerated miss arrives
    a_r8_unlock_after_misses: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lk_q.lock) |-> ($past(lk_q.misses) == MISS_LAST));
endmodule

// File: rtl/vlock_flywheel.sv
module vlock_flywheel
    import vlock_pkg::*;
#(
    parameter int WIN_H         = 2,
    parameter int LOCK_FIELDS   = 4,
    parameter int UNLOCK_FIELDS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic h_tick,
    input  logic csync_vpulse,
    input  logic pin_vpulse,
    input  logic ref_sel,
    input  logic int_vpulse,
    output logic lock,
    output logic rephase
);
    logic     ref_now;
    logic     ref_recent;
    fld_evt_e fld_evt;

    vlock_ref_track #(.WIN_H(WIN_H)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .h_tick       (h_tick),
        .csync_vpulse (csync_vpulse),
        .pin_vpulse   (pin_vpulse),
        .ref_sel      (ref_sel),
        .ref_now      (ref_now),
        .ref_recent   (ref_recent)
    );

    vlock_window #(.WIN_H(WIN_H)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_tick     (h_tick),
        .int_vpulse (int_vpulse),
        .ref_now    (ref_now),
        .ref_recent (ref_recent),
        .fld_evt    (fld_evt)
    );

    vlock_state #(
        .LOCK_FIELDS   (LOCK_FIELDS),
        .UNLOCK_FIELDS (UNLOCK_FIELDS)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_now (ref_now),
        .fld_evt (fld_evt),
        .lock    (lock),
        .rephase (rephase)
    );

    // R3: while unlocked, every selected reference pulse is followed by a rephase
    a_r3_rephase_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_now && !lock) |=> rephase);

    // R3: a rephase is always caused by a selected reference pulse
    a_r3_rephase_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rephase |-> $past(ref_now));
endmodule

// File: tb/sim_vlock_flywheel.sv
module sim_vlock_flywheel;
    localparam int WIN_H    = 2;
    localparam int LOCK_N   = 4;
    localparam int UNLOCK_N = 8;
    localparam int FLD_LEN  = 160;
    localparam int INT_AT   = 82;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_tick = 1'b0;
    logic csync_vp = 1'b0;
    logic pin_vp = 1'b0;
    logic sel = 1'b0;
    logic ivp = 1'b0;
    logic lock;
    logic rephase;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vlock_flywheel #(
        .WIN_H(WIN_H), .LOCK_FIELDS(LOCK_N), .UNLOCK_FIELDS(UNLOCK_N)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .h_tick(h_tick),
        .csync_vpulse(csync_vp), .pin_vpulse(pin_vp), .ref_sel(sel),
        .int_vpulse(ivp), .lock(lock), .rephase(rephase)
    );

    // Behavioural reference model: cumulative tick counts and field counters
    int  m_cum;       // ticks in all cycles before the current one
    int  m_ref_mark;  // tick count through the last reference cycle
    bit  m_ref_valid;
    bit  m_open;
    int  m_int_mark;
    int  m_hits;
    int  m_misses;
    bit  m_lock;
    bit  m_reph;

    always @(posedge clk) begin
        bit r;
        int ev;  // 0 none, 1 hit, 2 miss
        if (!rst_n) begin
            m_cum = 0; m_ref_valid = 0; m_ref_mark = 0; m_open = 0;
            m_int_mark = 0; m_hits = 0; m_misses = 0; m_lock = 0; m_reph = 0;
        end else begin
            r  = sel ? pin_vp : csync_vp;
            ev = 0;
            if (m_open) begin
                if (r) begin
                    ev = 1; m_open = 0;
                end else if (h_tick && (m_cum - m_int_mark == WIN_H)) begin
                    ev = 2; m_open = 0;
                end
            end else if (ivp) begin
                if (r || (m_ref_valid && (m_cum - m_ref_mark <= WIN_H))) ev = 1;
                else begin
                    m_open = 1; m_int_mark = m_cum + int'(h_tick);
                end
            end
            if (r) begin
                m_ref_valid = 1; m_ref_mark = m_cum + int'(h_tick);
            end
            m_cum += int'(h_tick);
            m_reph = r && !m_lock;
            if (!m_lock) begin
                if (ev == 1) begin
                    m_hits++;
                    if (m_hits == LOCK_N) begin m_lock = 1; m_hits = 0; m_misses = 0; end
                end else if (ev == 2) m_hits = 0;
            end else begin
                if (ev == 2) begin
                    m_misses++;
                    if (m_misses == UNLOCK_N) begin m_lock = 0; m_hits = 0; m_misses = 0; end
                end else if (ev == 1) m_misses = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (lock !== m_lock || rephase !== m_reph) begin
                n_fail++;
                $display("FAIL model R3/R5/R7/R8 t=%0t lock=%0b rephase=%0b expected lock=%0b rephase=%0b",
                         $time, lock, rephase, m_lock, m_reph);
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // One field: internal pulse at INT_AT, reference d horizontal periods away
    task automatic run_field(input int d, input bit has_ref, input bit on_pin,
                             input bit noise, output int reph_cnt);
        reph_cnt = 0;
        for (int c = 0; c < FLD_LEN; c++) begin
            h_tick   = (c % 4 == 0);
            ivp      = (c == INT_AT);
            csync_vp = 1'b0;
            pin_vp   = 1'b0;
            if (has_ref && c == INT_AT + 4 * d) begin
                if (on_pin) pin_vp = 1'b1; else csync_vp = 1'b1;
            end
            if (noise && c == 30) begin
                if (on_pin) csync_vp = 1'b1; else pin_vp = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            reph_cnt += int'(rephase);
        end
    endtask

    initial begin
        int rc;
        repeat (3) @(negedge clk);
        chk(lock == 1'b0 && rephase == 1'b0, "R1 reset outputs", int'(lock) + int'(rephase), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lock == 1'b0 && rephase == 1'b0, "R1 first cycle after reset", int'(lock) + int'(rephase), 0);

        // Unlocked: hits build up, rephase follows each reference
        for (int i = 0; i < 3; i++) begin
            run_field(0, 1, 0, 1, rc);
            chk(rc == 1, "R3 one rephase per unlocked field", rc, 1);
            chk(lock == 1'b0, "R5 no lock before threshold", int'(lock), 0);
        end
        run_field(0, 0, 0, 0, rc);
        chk(lock == 1'b0, "R6 missing reference is a miss", int'(lock), 0);
        run_field(1, 1, 0, 0, rc);
        run_field(-1, 1, 0, 0, rc);
        run_field(2, 1, 0, 0, rc);
        chk(lock == 1'b0, "R6 hit count restarted by miss", int'(lock), 0);
        run_field(-2, 1, 0, 0, rc);
        chk(lock == 1'b1, "R5 lock after four hits, R4 edge offsets", int'(lock), 1);

        // Locked: reference pulses and noise give no rephase
        run_field(0, 1, 0, 1, rc);
        chk(rc == 0, "R7 no rephase while locked", rc, 0);
        for (int i = 0; i < UNLOCK_N - 1; i++) run_field(3, 1, 0, 1, rc);
        chk(lock == 1'b1, "R8 lock held through seven misses", int'(lock), 1);
        chk(rc == 0, "R7 no rephase on locked miss field", rc, 0);
        run_field(1, 1, 0, 0, rc);
        for (int i = 0; i < UNLOCK_N - 1; i++) run_field(-3, 1, 0, 0, rc);
        chk(lock == 1'b1, "R8 hit cleared the miss count", int'(lock), 1);
        run_field(-3, 1, 0, 0, rc);
        chk(lock == 1'b0, "R8 unlock after eight misses", int'(lock), 0);

        // Window boundary while unlocked
        for (int i = 0; i < 3; i++) run_field(0, 1, 0, 0, rc);
        run_field(3, 1, 0, 0, rc);
        chk(lock == 1'b0, "R4 three periods apart is a miss", int'(lock), 0);
        for (int i = 0; i < 4; i++) run_field(2, 1, 0, 0, rc);
        chk(lock == 1'b1, "R4 two periods apart is a hit", int'(lock), 1);

        // Source select: dedicated input chosen, composite line ignored
        sel = 1'b1;
        for (int i = 0; i < UNLOCK_N; i++) run_field(0, 1, 0, 0, rc);
        chk(lock == 1'b0, "R2 unselected line gives no hits", int'(lock), 0);
        run_field(0, 1, 0, 0, rc);
        chk(rc == 0, "R2 unselected line gives no rephase", rc, 0);
        for (int i = 0; i < LOCK_N; i++) begin
            run_field(-1, 1, 1, 1, rc);
            if (i == 0) chk(rc == 1, "R2 selected pin line rephases", rc, 1);
        end
        chk(lock == 1'b1, "R2 lock on dedicated input", int'(lock), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule